// File: doc/BRIEF.md
# User Address-Range Monitor Arm Tracker

This block records whether a user-level address monitor is currently armed, and which cache line it is watching. An arm request brings in a byte address and a flag saying whether the request succeeded. A successful request stores the line of that address and arms the monitor. A failed request leaves the monitor disarmed, so that a later wait does not go to sleep. Retirement of certain control-transfer instructions disarms the monitor, and so does any use of the older monitor mechanism, because the two mechanisms cannot be mixed.

A snoop channel reports store addresses and the class of agent that issued each store. A store from another processor agent, or from a non-processor agent, that lands in the armed line produces a one-cycle wake pulse for the wait controller and disarms the monitor. Stores from the local thread are ignored. The wait controller reads the armed flag to decide whether to sleep at all, and uses the wake pulse to end the sleep.

Top module: `umon_arm_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `armed` is 0 and `wake` is 0.
- R2: An arm strobe with `arm_ok`=1 and no disarm event in the same cycle sets `armed` to 1 on the next clock edge and stores the line of `arm_addr`.
- R3: An arm strobe with `arm_ok`=0 clears `armed` on the next clock edge. A following store to the previously watched line does not fire `wake`.
- R4: Each of the four retire strobes (interrupt return, system exit, system return, far return that changes privilege) clears `armed` on the next clock edge.
- R5: The legacy-monitor strobe clears `armed` on the next clock edge.
- R6: A valid snoop with `snp_src`=2'b01 (other processor agent) or 2'b10 (non-processor agent) that hits the armed line drives `wake` high for exactly the one cycle after the snoop.
- R7: A snoop with `snp_src`=2'b00 (local thread) or 2'b11 (reserved) never fires `wake` and leaves `armed` unchanged.
- R8: A hit compares only the address bits above the line offset (the low 6 bits for the default 64-byte line). Addresses that differ only in the offset hit, and addresses in the next line do not.
- R9: Firing `wake` also clears `armed`, so a second store to the same line does not fire again.
- R10: When an arm strobe falls in the same cycle as a retire strobe, a legacy-monitor strobe or a firing hit, `armed` is 0 after that edge.
- R11: A new successful arm replaces the stored line. Stores to the old line no longer fire, and stores to the new line do.
- R12: A store while the monitor is disarmed never fires `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_vld | input | 1 | Arm request strobe |
| arm_addr | input | ADDR_W | Byte address to watch |
| arm_ok | input | 1 | Arm request succeeded |
| ret_iret | input | 1 | Interrupt return retired |
| ret_sysexit | input | 1 | System-exit retired |
| ret_sysret | input | 1 | System-return retired |
| ret_far_cpl | input | 1 | Far return with privilege change retired |
| legacy_mon | input | 1 | Legacy monitor instruction executed |
| snp_vld | input | 1 | Snooped store valid |
| snp_addr | input | ADDR_W | Snooped store byte address |
| snp_src | input | 2 | Store originator class: 00 local, 01 processor, 10 device, 11 reserved |
| armed | output | 1 | Monitor armed |
| wake | output | 1 | One-cycle trigger to the wait controller |

## Verification
The assertions check on every cycle that each disarm source clears the armed flag on the next edge, that a clean successful arm sets it, that a wake pulse always follows an armed cycle and leaves the monitor disarmed, and that local-thread stores never produce a wake. The bench scenarios cover what a property cannot show on its own: that offset-only address differences still hit while the next line misses, that a replacing arm retires the old line, and how arms, disarms and hits resolve when they fall in the same cycle. A long mixed-traffic run is compared against a behavioural model on every clock.

// File: rtl/umon_pkg.sv
package umon_pkg;
  typedef enum logic [1:0] {
    SRC_LOCAL  = 2'b00,
    SRC_PEER   = 2'b01,
    SRC_DEVICE = 2'b10,
    SRC_RSVD   = 2'b11
  } umon_src_e;

  localparam int unsigned N_RETIRE = 4;

  function automatic logic src_is_remote(input logic [1:0] src);
    return (src == SRC_PEER) || (src == SRC_DEVICE);
  endfunction
endpackage

// File: rtl/umon_disarm_decode.sv
module umon_disarm_decode
  import umon_pkg::*;
(
  input  logic [N_RETIRE-1:0] retire_vec,
  input  logic                legacy_mon,
  output logic                kill
);
  logic [N_RETIRE:0] chain;

  assign chain[0] = legacy_mon;
  for (genvar i = 0; i < N_RETIRE; i++) begin : g_or
    assign chain[i+1] = chain[i] | retire_vec[i];
  end
  assign kill = chain[N_RETIRE];
endmodule

// File: rtl/umon_line_match.sv
module umon_line_match
  import umon_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned TAG_W  = 42
) (
  input  logic              snp_vld,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [1:0]        snp_src,
  input  logic              armed_q,
  input  logic [TAG_W-1:0]  tag_q,
  output logic              hit
);
  localparam int unsigned OFF_W = ADDR_W - TAG_W;

  logic [TAG_W-1:0] snp_tag;
  logic             tag_eq;
  logic             remote;

  assign snp_tag = snp_addr[ADDR_W-1:OFF_W];
  assign tag_eq  = (snp_tag == tag_q);
  assign remote  = src_is_remote(snp_src);

  always_comb begin
    hit = 1'b0;
    if (snp_vld && armed_q && remote && tag_eq) begin
      hit = 1'b1;
    end
  end
endmodule

// File: rtl/umon_state.sv
module umon_state #(
  parameter int unsigned TAG_W = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_req,
  input  logic             arm_ok,
  input  logic [TAG_W-1:0] arm_tag,
  input  logic             kill,
  input  logic             hit,
  output logic             armed_q,
  output logic             wake_q,
  output logic [TAG_W-1:0] tag_q
);
  logic             armed_d;
  logic             wake_d;
  logic [TAG_W-1:0] tag_d;
  logic             tag_en;

  always_comb begin
    armed_d = armed_q;
    tag_en  = 1'b0;
    wake_d  = hit;
    if (kill || hit) begin
      armed_d = 1'b0;
    end else if (arm_req) begin
      armed_d = arm_ok;
      tag_en  = arm_ok;
    end
    tag_d = tag_en ? arm_tag : tag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      wake_q  <= 1'b0;
      tag_q   <= '0;
    end else begin
      armed_q <= armed_d;
      wake_q  <= wake_d;
      if (tag_en) begin
        tag_q <= tag_d;
      end
    end
  end

  // R4
  kill_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !armed_q);

  // R2
  clean_arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && arm_ok && !kill && !hit) |=> armed_q);

  // R3
  failed_arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && !arm_ok) |=> !armed_q);

  // R9
  hit_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (wake_q && !armed_q));
endmodule

// File: rtl/umon_arm_tracker.sv
module umon_arm_tracker
  import umon_pkg::*;
#(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_vld,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic              arm_ok,
  input  logic              ret_iret,
  input  logic              ret_sysexit,
  input  logic              ret_sysret,
  input  logic              ret_far_cpl,
  input  logic              legacy_mon,
  input  logic              snp_vld,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [1:0]        snp_src,
  output logic              armed,
  output logic              wake
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);
  localparam int unsigned TAG_W = ADDR_W - OFF_W;

  logic                kill;
  logic                hit;
  logic                armed_q;
  logic                wake_q;
  logic [TAG_W-1:0]    tag_q;
  logic [N_RETIRE-1:0] retire_vec;

  assign retire_vec = {ret_far_cpl, ret_sysret, ret_sysexit, ret_iret};

  umon_disarm_decode u_dec (
    .retire_vec (retire_vec),
    .legacy_mon (legacy_mon),
    .kill       (kill)
  );

  umon_line_match #(
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W)
  ) u_match (
    .snp_vld  (snp_vld),
    .snp_addr (snp_addr),
    .snp_src  (snp_src),
    .armed_q  (armed_q),
    .tag_q    (tag_q),
    .hit      (hit)
  );

  umon_state #(
    .TAG_W (TAG_W)
  ) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_req (arm_vld),
    .arm_ok  (arm_ok),
    .arm_tag (arm_addr[ADDR_W-1:OFF_W]),
    .kill    (kill),
    .hit     (hit),
    .armed_q (armed_q),
    .wake_q  (wake_q),
    .tag_q   (tag_q)
  );

  assign armed = armed_q;
  assign wake  = wake_q;

  // R5
  legacy_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_mon |=> !armed);

  // R7
  local_store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_vld && (snp_src == SRC_LOCAL)) |=> !wake);

  // R12
  wake_needs_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(armed));

  // R9
  wake_leaves_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !armed);
endmodule

// File: tb/sim_umon_arm_tracker.sv
module sim_umon_arm_tracker;
  localparam int ADDR_W = 48;
  localparam int OFF_W  = 6;

  logic              clk;
  logic              rst_n;
  logic              arm_vld;
  logic [ADDR_W-1:0] arm_addr;
  logic              arm_ok;
  logic [3:0]        ret;
  logic              legacy_mon;
  logic              snp_vld;
  logic [ADDR_W-1:0] snp_addr;
  logic [1:0]        snp_src;
  logic              armed;
  logic              wake;

  int n_chk = 0;
  int n_bad = 0;
  int n_cyc = 0;
  bit cmp_en = 0;

  // behavioural reference
  bit                  m_armed;
  bit                  m_wake;
  logic [ADDR_W-1:0]   m_line;

  umon_arm_tracker u0 (
    .clk (clk), .rst_n (rst_n),
    .arm_vld (arm_vld), .arm_addr (arm_addr), .arm_ok (arm_ok),
    .ret_iret (ret[0]), .ret_sysexit (ret[1]), .ret_sysret (ret[2]),
    .ret_far_cpl (ret[3]), .legacy_mon (legacy_mon),
    .snp_vld (snp_vld), .snp_addr (snp_addr), .snp_src (snp_src),
    .armed (armed), .wake (wake)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected below 50000", n_cyc);
      summary();
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0;
      m_wake  = 0;
      m_line  = '0;
    end else begin
      bit same_line;
      bit remote;
      bit fire;
      same_line = (snp_addr >> OFF_W) == (m_line >> OFF_W);
      remote    = (snp_src == 2'd1) || (snp_src == 2'd2);
      fire      = snp_vld && m_armed && remote && same_line;
      m_wake    = fire;
      if (fire || legacy_mon || (ret != 0)) m_armed = 0;
      else if (arm_vld) begin
        m_armed = arm_ok;
        if (arm_ok) m_line = arm_addr;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      n_chk++;
      if (armed !== m_armed || wake !== m_wake) begin
        n_bad++;
        $display("FAIL model R2 R6: actual armed=%0b wake=%0b expected armed=%0b wake=%0b",
                 armed, wake, m_armed, m_wake);
      end
    end
  end

  task automatic chk(input string req, input bit ea, input bit ew);
    n_chk++;
    if (armed !== ea || wake !== ew) begin
      n_bad++;
      $display("FAIL %s: actual armed=%0b wake=%0b expected armed=%0b wake=%0b",
               req, armed, wake, ea, ew);
    end
  endtask

  task automatic clr();
    arm_vld = 0; arm_addr = '0; arm_ok = 0; ret = 0; legacy_mon = 0;
    snp_vld = 0; snp_addr = '0; snp_src = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clr();
  endtask

  task automatic do_arm(input logic [ADDR_W-1:0] a, input bit ok);
    arm_vld = 1; arm_addr = a; arm_ok = ok;
    tick();
  endtask

  task automatic do_store(input logic [ADDR_W-1:0] a, input logic [1:0] s);
    snp_vld = 1; snp_addr = a; snp_src = s;
    tick();
  endtask

  localparam logic [ADDR_W-1:0] LA = 48'h0000_1234_5640;
  localparam logic [ADDR_W-1:0] LB = 48'h0000_0abc_de00;

  initial begin
    clr();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 0, 0);
    rst_n = 1;
    tick();
    chk("R1 after reset", 0, 0);
    cmp_en = 1;

    do_store(LA, 2'd1);            chk("R12", 0, 0);
    do_arm(LA, 1);                 chk("R2", 1, 0);
    do_store(LA, 2'd0);            chk("R7 local", 1, 0);
    do_store(LA, 2'd3);            chk("R7 reserved", 1, 0);
    do_store(LA + 48'h3F, 2'd1);   chk("R8 offset hit", 0, 1);
    tick();                        chk("R6 single pulse", 0, 0);
    do_store(LA, 2'd1);            chk("R9 no refire", 0, 0);

    do_arm(LA, 1);                 chk("R2 rearm", 1, 0);
    do_store(LA + 48'h40, 2'd2);   chk("R8 next line", 1, 0);
    do_store(LA, 2'd2);            chk("R6 device", 0, 1);

    do_arm(LA, 1);
    do_arm(LB, 0);                 chk("R3 failed arm", 0, 0);
    do_store(LA, 2'd1);            chk("R3 old line quiet", 0, 0);

    for (int i = 0; i < 4; i++) begin
      do_arm(LA, 1);
      ret[i] = 1;
      tick();                      chk("R4 retire", 0, 0);
    end

    do_arm(LA, 1);
    legacy_mon = 1; tick();        chk("R5 legacy", 0, 0);

    arm_vld = 1; arm_addr = LA; arm_ok = 1; ret[0] = 1;
    tick();                        chk("R10 arm+retire", 0, 0);
    arm_vld = 1; arm_addr = LA; arm_ok = 1; legacy_mon = 1;
    tick();                        chk("R10 arm+legacy", 0, 0);
    do_arm(LA, 1);
    arm_vld = 1; arm_addr = LB; arm_ok = 1;
    snp_vld = 1; snp_addr = LA; snp_src = 2'd1;
    tick();                        chk("R10 arm+hit", 0, 1);
    do_store(LB, 2'd1);            chk("R10 new line not armed", 0, 0);

    do_arm(LA, 1);
    do_arm(LB, 1);                 chk("R11 replace", 1, 0);
    do_store(LA, 2'd1);            chk("R11 old line", 1, 0);
    do_store(LB + 48'h11, 2'd2);   chk("R11 new line", 0, 1);

    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 15) begin
        arm_vld = 1; arm_ok = ($urandom_range(0, 7) != 0);
        arm_addr = ($urandom_range(0, 1) != 0) ? LA : LB;
      end
      if (r >= 10 && r < 70) begin
        snp_vld = 1; snp_src = 2'($urandom_range(0, 3));
        snp_addr = (($urandom_range(0, 1) != 0) ? LA : LB) + 48'($urandom_range(0, 127));
      end
      if (r >= 95) ret[$urandom_range(0, 3)] = 1;
      if (r == 94) legacy_mon = 1;
      tick();
    end

    summary();
  end
endmodule